// File: doc/BRIEF.md
# Multi-Core Interrupt Router

This block takes a bank of level-sensitive interrupt sources and steers each one to a single core. Each core has four parent interrupt lines. Every source carries a raw pending bit, an enable bit and a status bit. The status bit is kept only at the core the source is currently routed to. A parent line `(core, line)` is high exactly while at least one status bit for that core belongs to a source group mapped onto that line. So the line rises with the first pending source of the group and falls when the last one clears. Two tables control the routing. A line table has one byte per group of 32 sources. A target table is written as one byte per source and decoded into a core number when it is written.

Configuration arrives as single-cycle update strobes carrying an operation code, a word index, a core number and a 64-bit data word. Source edges are handled for every source in parallel on every cycle. An update that can touch several sources builds a work mask. The block then processes that mask one source per clock, lowest number first, and holds `busy` high while it does so. Two mode bits choose how the table bytes are read: as a plain binary number or as a one-hot mask.

Top module: `irq_route_core`

## Requirements
- R1: After reset, every parent line is low, `busy` is low, every source routes to core 0, all enables are clear, and both mode bits are clear.
- R2: When a source input rises, its status bit is set at its routed core only if its enable bit is set. The matching parent line reflects this one clock after the edge. A rise on a disabled source leaves every parent line unchanged.
- R3: A falling input always clears that source's status bit. A parent line stays high while any other pending source of the same core and line remains, and drops when the last one clears.
- R4: Line-table byte g sits in `upd_data[8g+7:8g]` of a line update and governs sources 32g to 32g+31. With mode bit 0 clear, the line is the position of the byte's lowest set bit. A zero byte, or a lowest set bit at position 4 or above, gives line 0.
- R5: With mode bit 0 set, the line is the low two bits of the line-table byte.
- R6: A route update with index n carries the target for source 8n+j in byte j of `upd_data`. With mode bit 1 clear, the target is the position of the lowest set bit, and a position of 4 or above gives core 0. A zero byte leaves the route unchanged.
- R7: With mode bit 1 set, the route byte is the core number itself. A value of NCORE or more leaves the route unchanged.
- R8: Re-routing a source whose raw pending bit is set lowers it at the old core and raises it at the new core. The raise happens only if the source is enabled.
- R9: An enable update for word w (sources 64w to 64w+63) raises every pending source whose enable goes from 0 to 1. It lowers every pending source whose enable goes from 1 to 0.
- R10: A clear update for core c and word w removes the status bits of that core that are set in `upd_data`. Each removed bit lowers its source.
- R11: An update is processed one affected source per clock, lowest number first. `busy` stays high for exactly as many cycles as there are affected sources, and an update presented while `busy` is high is ignored.
- R12: An input edge on the source being processed in the current cycle takes effect one cycle later. Both operations are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NIRQ | Level of each interrupt source |
| upd_valid | input | 1 | Update strobe, one cycle |
| upd_op | input | 3 | 0 enable, 1 status clear, 2 route, 3 line table, 4 mode |
| upd_idx | input | log2(NIRQ/8) | Word index (64 sources for enable/clear, 8 sources for route) |
| upd_core | input | log2(NCORE) | Core whose status a clear update targets |
| upd_data | input | 64 | Update payload; for mode, bit 0 encodes lines and bit 1 encodes cores |
| busy | output | 1 | High while queued sources are being processed |
| parent_irq | output | NCORE*4 | Parent lines, bit core*4+line, registered |

## Verification
The serial scanner and the parallel edge logic can both want the same source in one cycle. The bench provokes this by queuing a re-route of one pending source and dropping that source's input so that the fall arrives at exactly the clock edge where the scanner moves it. The expected result is that the new core's line goes high in that cycle and falls one cycle later. A second overlap is an update strobe presented while the scanner is working; it is judged by confirming that the enables it would have cleared leave the parent lines untouched.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [2:0] {
        OP_ENABLE = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_ROUTE  = 3'd2,
        OP_LINES  = 3'd3,
        OP_MODE   = 3'd4
    } rt_op_e;

    localparam int LINES_PER_CORE = 4;
    localparam int GROUP_SIZE     = 32;

    // position of lowest set bit, 8 when the byte is empty
    function automatic logic [3:0] low_pos8(input logic [7:0] b);
        logic [3:0] p;
        p = 4'd8;
        for (int k = 7; k >= 0; k--) begin
            if (b[k]) p = 4'(k);
        end
        return p;
    endfunction

    function automatic logic [1:0] line_of(input logic [7:0] b, input logic enc);
        logic [3:0] p;
        p = low_pos8(b);
        if (enc) return b[1:0];
        return (p < 4'd4) ? p[1:0] : 2'd0;
    endfunction

endpackage

// File: rtl/rt_pick.sv
module rt_pick #(
    parameter int W  = 64,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec[k]) idx = IW'(k);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/rt_parent.sv
module rt_parent
    import rt_pkg::*;
#(
    parameter int NIRQ  = 256,
    parameter int NCORE = 4,
    localparam int NGRP = NIRQ / GROUP_SIZE
) (
    input  logic [NCORE*NIRQ-1:0]           status,
    input  logic [NGRP*8-1:0]               linemap,
    input  logic                            line_enc,
    output logic [NCORE*LINES_PER_CORE-1:0] lines
);
    logic [LINES_PER_CORE-1:0][NIRQ-1:0] lmask;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [1:0] sel;
        assign sel = line_of(linemap[g*8 +: 8], line_enc);
        for (genvar l = 0; l < LINES_PER_CORE; l++) begin : g_ln
            assign lmask[l][g*GROUP_SIZE +: GROUP_SIZE] = {GROUP_SIZE{sel == 2'(l)}};
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar l = 0; l < LINES_PER_CORE; l++) begin : g_out
            assign lines[c*LINES_PER_CORE + l] = |(status[c*NIRQ +: NIRQ] & lmask[l]);
        end
    end
endmodule

// File: rtl/irq_route_core.sv
module irq_route_core
    import rt_pkg::*;
#(
    parameter int NIRQ  = 256,
    parameter int NCORE = 4,
    localparam int CW    = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int IRQW  = $clog2(NIRQ),
    localparam int IDXW  = $clog2(NIRQ / 8),
    localparam int NWORD = NIRQ / 64,
    localparam int NGRP  = NIRQ / GROUP_SIZE,
    localparam int NPAR  = NCORE * LINES_PER_CORE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_in,
    input  logic            upd_valid,
    input  logic [2:0]      upd_op,
    input  logic [IDXW-1:0] upd_idx,
    input  logic [CW-1:0]   upd_core,
    input  logic [63:0]     upd_data,
    output logic            busy,
    output logic [NPAR-1:0] parent_irq
);
    typedef struct packed {
        logic [NIRQ-1:0]                raw;
        logic [NIRQ-1:0]                enable;
        logic [NCORE-1:0][NIRQ-1:0]     status;
        logic [NIRQ-1:0][CW-1:0]        route;
        logic [NGRP*8-1:0]              linemap;
        logic [1:0]                     mode;
        rt_op_e                         op;
        logic [IRQW-1:0]                base;
        logic [63:0]                    work;
        logic [63:0]                    data;
    } st_t;

    st_t st_q, st_d;
    logic [NPAR-1:0] parent_q, parent_d;
    logic [5:0]      pick_idx;
    logic            pick_any;
    logic [IRQW-1:0] scan_irq;

    // MSB: decode valid, low bits: target core
    function automatic logic [CW:0] core_of(input logic [7:0] b, input logic enc);
        int v;
        if (enc) begin
            v = int'(b);
        end else begin
            if (b == 8'd0) return '0;
            v = (low_pos8(b) < 4'd4) ? int'(low_pos8(b)) : 0;
        end
        if (v < NCORE) return {1'b1, CW'(v)};
        return '0;
    endfunction

    rt_pick #(.W(64)) u_pick (
        .vec (st_q.work),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign busy     = pick_any;
    assign scan_irq = st_q.base + IRQW'(pick_idx);

    always_comb begin
        logic [CW:0] r;
        int          w;
        int          k;
        st_d = st_q;
        w    = int'(upd_idx);
        k    = int'(scan_irq);
        r    = '0;

        if (upd_valid && !pick_any) begin
            case (rt_op_e'(upd_op))
                OP_ENABLE: if (w < NWORD) begin
                    st_d.enable[w*64 +: 64] = upd_data;
                    st_d.work = (upd_data ^ st_q.enable[w*64 +: 64]) & st_q.raw[w*64 +: 64];
                    st_d.op   = OP_ENABLE;
                    st_d.base = IRQW'(w * 64);
                end
                OP_CLEAR: if (w < NWORD && int'(upd_core) < NCORE) begin
                    st_d.work = upd_data & st_q.status[upd_core][w*64 +: 64];
                    st_d.op   = OP_CLEAR;
                    st_d.base = IRQW'(w * 64);
                end
                OP_ROUTE: begin
                    for (int j = 0; j < 8; j++) begin
                        r = core_of(upd_data[j*8 +: 8], st_q.mode[1]);
                        st_d.work[j] = r[CW] && (r[CW-1:0] != st_q.route[w*8 + j]);
                    end
                    st_d.data = upd_data;
                    st_d.op   = OP_ROUTE;
                    st_d.base = IRQW'(w * 8);
                end
                OP_LINES: st_d.linemap = upd_data[NGRP*8-1:0];
                OP_MODE:  st_d.mode    = upd_data[1:0];
                default: ;
            endcase
        end

        if (pick_any) begin
            st_d.work[pick_idx] = 1'b0;
            case (st_q.op)
                OP_ENABLE: st_d.status[st_q.route[k]][k] = st_q.enable[k] & st_q.raw[k];
                OP_CLEAR:  st_d.status[st_q.route[k]][k] = 1'b0;
                OP_ROUTE: begin
                    r = core_of(st_q.data[int'(pick_idx)*8 +: 8], st_q.mode[1]);
                    st_d.status[st_q.route[k]][k] = 1'b0;
                    st_d.route[k]                 = r[CW-1:0];
                    st_d.status[r[CW-1:0]][k]     = st_q.enable[k] & st_q.raw[k];
                end
                default: ;
            endcase
        end

        // source edges, all in parallel; the scanned source waits a cycle
        for (int i = 0; i < NIRQ; i++) begin
            if (!(pick_any && k == i)) begin
                st_d.raw[i] = irq_in[i];
                if (irq_in[i] && !st_q.raw[i] && st_d.enable[i])
                    st_d.status[st_q.route[i]][i] = 1'b1;
                else if (!irq_in[i] && st_q.raw[i])
                    st_d.status[st_q.route[i]][i] = 1'b0;
            end
        end
    end

    rt_parent #(.NIRQ(NIRQ), .NCORE(NCORE)) u_parent (
        .status   (st_d.status),
        .linemap  (st_d.linemap),
        .line_enc (st_d.mode[0]),
        .lines    (parent_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            parent_q <= '0;
        end else begin
            st_q     <= st_d;
            parent_q <= parent_d;
        end
    end

    assign parent_irq = parent_q;

    // R3
    status_in_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status[0] & ~st_q.raw) == '0);

    // R11
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |=> ($countones(st_q.work) == $past($countones(st_q.work)) - 1));

    // R8
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_any |=> $stable(st_q.route));

    for (genvar i = 0; i < NIRQ; i++) begin : g_own
        logic [NCORE-1:0] col;
        for (genvar c = 0; c < NCORE; c++) begin : g_col
            assign col[c] = st_q.status[c][i];
        end
        // R8
        single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_idle
        // R3
        parent_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.status[c] == '0) |-> (parent_q[c*LINES_PER_CORE +: LINES_PER_CORE] == '0));
    end
endmodule

// File: tb/irq_route_core_tb.sv
module irq_route_core_tb;
    import rt_pkg::*;

    localparam int NIRQ  = 256;
    localparam int NCORE = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [255:0]   irq_in = '0;
    logic           upd_valid = 1'b0;
    logic [2:0]     upd_op = '0;
    logic [4:0]     upd_idx = '0;
    logic [1:0]     upd_core = '0;
    logic [63:0]    upd_data = '0;
    logic           busy;
    logic [15:0]    parent_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_route_core #(.NIRQ(NIRQ), .NCORE(NCORE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .upd_valid(upd_valid),
        .upd_op(upd_op), .upd_idx(upd_idx), .upd_core(upd_core),
        .upd_data(upd_data), .busy(busy), .parent_irq(parent_irq)
    );

    // [24:17] source, [16] level, [15:0] expected parent lines
    localparam logic [24:0] VEC [9] = '{
        {8'd40,  1'b1, 16'h0005},
        {8'd70,  1'b1, 16'h0007},
        {8'd100, 1'b1, 16'h0007},
        {8'd5,   1'b0, 16'h0007},
        {8'd100, 1'b0, 16'h0006},
        {8'd130, 1'b1, 16'h000E},
        {8'd40,  1'b0, 16'h000A},
        {8'd70,  1'b0, 16'h0008},
        {8'd130, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input rt_op_e op, input int idx, input int core, input logic [63:0] d);
        upd_valid = 1'b1;
        upd_op    = op;
        upd_idx   = 5'(idx);
        upd_core  = 2'(core);
        upd_data  = d;
        tick();
        upd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) tick();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) tick();
        chk("R1 parent after reset", 64'(parent_irq), 64'h0);
        chk("R1 busy after reset", 64'(busy), 64'h0);
        rst_n = 1'b1;
        tick();

        // R2: rising on a disabled source
        irq_in[5] = 1'b1;
        tick();
        chk("R2 disabled rise", 64'(parent_irq), 64'h0);

        // R9: enable with source already pending
        send(OP_ENABLE, 0, 0, '1);
        wait_idle();
        chk("R9 enable raises pending", 64'(parent_irq), 64'h0001);
        for (int w = 1; w < 4; w++) begin
            send(OP_ENABLE, w, 0, '1);
            wait_idle();
        end

        // R4: one-hot line table
        send(OP_LINES, 0, 0, 64'h00000008_100A0400);
        for (int v = 0; v < 9; v++) begin
            irq_in[VEC[v][24:17]] = VEC[v][16];
            tick();
            chk($sformatf("R2/R3/R4 vector %0d", v), 64'(parent_irq), 64'(VEC[v][15:0]));
        end

        // R6 and R11: one-hot routes, three changes queued
        send(OP_ROUTE, 1, 0, 64'h00000008_20000402);
        cnt = 0;
        while (busy) begin
            cnt++;
            tick();
        end
        chk("R11 busy cycles", 64'(cnt), 64'd3);
        irq_in[12:8] = 5'h1F;
        tick();
        chk("R6 one-hot routing", 64'(parent_irq), 64'h1111);

        // R8, R11: move pending 8 and 9 to core 3, lowest first; update while busy ignored
        send(OP_ROUTE, 1, 0, 64'h00000008_20000808);
        chk("R11 busy after accept", 64'(busy), 64'h1);
        send(OP_ENABLE, 0, 0, 64'h0);
        chk("R8 R11 first move", 64'(parent_irq), 64'h1101);
        tick();
        chk("R8 second move", 64'(parent_irq), 64'h1001);
        chk("R11 idle after work", 64'(busy), 64'h0);

        // R10: write-one-clear per core
        send(OP_CLEAR, 0, 3, 64'h1300);
        wait_idle();
        chk("R10 clear core3", 64'(parent_irq), 64'h0001);
        send(OP_CLEAR, 0, 0, 64'h0400);
        wait_idle();
        chk("R10 R3 partial clear", 64'(parent_irq), 64'h0001);
        send(OP_CLEAR, 0, 0, 64'h0800);
        wait_idle();
        chk("R10 last clear", 64'(parent_irq), 64'h0000);

        // R9: enable transitions with sources pending
        send(OP_ENABLE, 0, 0, 64'h0);
        wait_idle();
        send(OP_ENABLE, 0, 0, '1);
        wait_idle();
        chk("R9 re-enable raises", 64'(parent_irq), 64'h1001);
        send(OP_ENABLE, 0, 0, 64'h0);
        wait_idle();
        chk("R9 disable lowers", 64'(parent_irq), 64'h0000);
        send(OP_ENABLE, 0, 0, '1);
        wait_idle();

        // R5, R7: encoded modes
        send(OP_MODE, 0, 0, 64'h3);
        send(OP_LINES, 0, 0, 64'h06);
        chk("R5 encoded line", 64'(parent_irq), 64'h4004);
        send(OP_ROUTE, 1, 0, 64'h00000003_00000701);
        wait_idle();
        chk("R7 encoded core", 64'(parent_irq), 64'h4044);

        // R12: fall on source 9 lands in the cycle it is moved
        send(OP_ROUTE, 1, 0, 64'h00000003_00000201);
        irq_in[9] = 1'b0;
        tick();
        chk("R12 move before deferred fall", 64'(parent_irq), 64'h4444);
        tick();
        chk("R12 deferred fall", 64'(parent_irq), 64'h4044);
        chk("R12 idle", 64'(busy), 64'h0);

        finish_run();
    end
endmodule